// File: doc/BRIEF.md
# Normalized Significand Divider with Rounding Word

This block divides one normalized 64-bit significand by another and prepares the result for a separate rounding stage. A start strobe captures both significands and both signed biased exponents. The block then produces a 64-bit quotient significand, a 32-bit rounding word and an adjusted result exponent, and marks completion with a one-cycle done pulse. A divisor whose top bit is clear is rejected at once through an error flag.

The quotient is built by a restoring loop that retires one bit per clock. When the dividend is not below the divisor, the divisor is first subtracted once. The finished quotient and rounding word are then shifted right by one place with a forced leading one, and the exponent is raised by one. When the low half of the divisor is zero, the rounding word holds 32 further exact quotient bits. Otherwise it is a coarse class code that describes the final remainder. Sign, special operands and the rounding step itself belong to the surrounding datapath.

Top module: `fdiv_core`

## Requirements
- R1: The base exponent is dvd_exp - dvs_exp + 16383, computed without overflow. When it is at or below -24576, it is replaced by -24576.
- R2: The reported res_exp equals the base exponent, plus 1 when the dividend significand is at least the divisor significand, minus 1.
- R3: When bit 63 of dvs_sig is 0 at the start strobe, done and err are high on the next cycle, quo and rnd are zero, and busy stays low. A later valid operation clears err.
- R4: When dvd_sig >= dvs_sig, let Q be floor((dvd_sig - dvs_sig) * 2^64 / dvs_sig). Then quo is {1, Q[63:1]}, and the top bit of rnd is Q[0], followed by the top 31 bits of the unshifted rounding word.
- R5: When dvd_sig < dvs_sig, quo is floor(dvd_sig * 2^64 / dvs_sig).
- R6: When the low 32 bits of dvs_sig are nonzero, let the remainder be R (before any shift). The unshifted rounding word is 32'h00000000 when R is zero, 32'h70000000 when 2R < divisor, 32'h80000000 when 2R equals the divisor, and 32'hFF000000 when 2R > divisor.
- R7: When the low 32 bits of dvs_sig are zero, the unshifted rounding word is the 32 quotient bits that follow the 64-bit quotient.
- R8: After reset, busy, done and err are low. A start strobe accepted while idle raises busy on the next cycle. Done is a one-cycle pulse 66 cycles after the accepting edge, or 97 cycles for a divisor with a zero low half, and busy is low while done is high.
- R9: A start strobe while busy is ignored, and the running operation completes with its original operands and timing.
- R10: For a normalized dividend and divisor, bit 63 of quo is set at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, sampled while idle |
| dvd_sig | input | 64 | Dividend significand |
| dvs_sig | input | 64 | Divisor significand, top bit expected set |
| dvd_exp | input | 16 | Dividend biased exponent, signed |
| dvs_exp | input | 16 | Divisor biased exponent, signed |
| quo | output | 64 | Quotient significand, valid with done |
| rnd | output | 32 | Rounding word, valid with done |
| res_exp | output | 18 | Result exponent, signed, valid with done |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divisor not normalized |

## Verification
The bench builds the block with its default parameters: 64-bit significands, a 32-bit rounding word, 16-bit exponents, bias 16383 and floor -24576. With 16-bit exponents, the exponent difference plus bias can fall well below the floor, so the clamp is reached with extreme exponent pairs. Because the short-divisor test only asks for a zero low half, a third of the random divisors take the 97-cycle extension path. A 160-bit behavioural division in the bench therefore covers the exact-extension mode and the class-code mode, including equal significands and the largest dividend over the smallest divisor.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DIV  = 3'd1,
        ST_EXT  = 3'd2,
        ST_CLS  = 3'd3,
        ST_ALN  = 3'd4
    } fdiv_state_e;

endpackage

// File: rtl/fdiv_exp_unit.sv
module fdiv_exp_unit #(
    parameter int EXP_W     = 16,
    parameter int EXP_BIAS  = 16383,
    parameter int EXP_FLOOR = -24576
) (
    input  logic signed [EXP_W-1:0] dvd_e,
    input  logic signed [EXP_W-1:0] dvs_e,
    output logic signed [EXP_W+1:0] base_e
);
    localparam int XW = EXP_W + 2;
    localparam logic signed [XW-1:0] FLOOR_V = XW'(EXP_FLOOR);
    localparam logic signed [XW-1:0] BIAS_V  = XW'(EXP_BIAS);

    logic signed [XW-1:0] dvd_x, dvs_x, diff;

    always_comb begin
        dvd_x = XW'(dvd_e);
        dvs_x = XW'(dvs_e);
        diff  = dvd_x - dvs_x + BIAS_V;
        // R1: clamp to the floor so tiny-over-huge stays representable
        base_e = (diff <= FLOOR_V) ? FLOOR_V : diff;
    end
endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_nxt,
    output logic         qbit
);
    logic [W:0] dbl, dv, diff;

    always_comb begin
        dbl     = {rem, 1'b0};
        dv      = {1'b0, dvs};
        diff    = dbl - dv;
        qbit    = (dbl >= dv);
        rem_nxt = qbit ? diff[W-1:0] : dbl[W-1:0];
    end
endmodule

// File: rtl/fdiv_round_class.sv
module fdiv_round_class #(
    parameter int SIG_W = 64,
    parameter int RW_W  = 32
) (
    input  logic [SIG_W-1:0] rem,
    input  logic [SIG_W-1:0] dvs,
    output logic [RW_W-1:0]  code
);
    localparam logic [RW_W-1:0] CODE_LT   = {4'b0111, {(RW_W-4){1'b0}}};
    localparam logic [RW_W-1:0] CODE_HALF = {1'b1, {(RW_W-1){1'b0}}};
    localparam logic [RW_W-1:0] CODE_GT   = {8'hFF, {(RW_W-8){1'b0}}};

    logic [SIG_W:0] dbl, dv;

    always_comb begin
        dbl = {rem, 1'b0};
        dv  = {1'b0, dvs};
        if (rem == '0)      code = '0;
        else if (dbl < dv)  code = CODE_LT;
        else if (dbl == dv) code = CODE_HALF;
        else                code = CODE_GT;
    end
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
    import fdiv_pkg::*;
#(
    parameter int SIG_W     = 64,
    parameter int RW_W      = 32,
    parameter int EXP_W     = 16,
    parameter int EXP_BIAS  = 16383,
    parameter int EXP_FLOOR = -24576
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SIG_W-1:0]        dvd_sig,
    input  logic [SIG_W-1:0]        dvs_sig,
    input  logic signed [EXP_W-1:0] dvd_exp,
    input  logic signed [EXP_W-1:0] dvs_exp,
    output logic [SIG_W-1:0]        quo,
    output logic [RW_W-1:0]         rnd,
    output logic signed [EXP_W+1:0] res_exp,
    output logic                    busy,
    output logic                    done,
    output logic                    err
);
    localparam int XW    = EXP_W + 2;
    localparam int CNT_W = $clog2(SIG_W);
    localparam int LO_W  = SIG_W / 2;
    localparam logic signed [XW-1:0] FLOOR_V = XW'(EXP_FLOOR);

    typedef struct packed {
        fdiv_state_e          fsm;
        logic [CNT_W-1:0]     cnt;
        logic [SIG_W-1:0]     rem;
        logic [SIG_W-1:0]     dvs;
        logic [SIG_W-1:0]     quo;
        logic [RW_W-1:0]      rnd;
        logic signed [XW-1:0] res_e;
        logic                 ovfl;
        logic                 short_dvs;
        logic                 done;
        logic                 err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic signed [XW-1:0] base_e;
    logic [SIG_W-1:0]     step_rem;
    logic                 step_bit;
    logic [RW_W-1:0]      cls_code;

    fdiv_exp_unit #(.EXP_W(EXP_W), .EXP_BIAS(EXP_BIAS), .EXP_FLOOR(EXP_FLOOR)) u_exp (
        .dvd_e(dvd_exp), .dvs_e(dvs_exp), .base_e(base_e)
    );

    fdiv_step #(.W(SIG_W)) u_step (
        .rem(regs_q.rem), .dvs(regs_q.dvs), .rem_nxt(step_rem), .qbit(step_bit)
    );

    fdiv_round_class #(.SIG_W(SIG_W), .RW_W(RW_W)) u_cls (
        .rem(regs_q.rem), .dvs(regs_q.dvs), .code(cls_code)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.fsm)
            ST_IDLE: begin
                if (start) begin
                    regs_d.quo   = '0;
                    regs_d.rnd   = '0;
                    regs_d.res_e = base_e;
                    if (!dvs_sig[SIG_W-1]) begin
                        regs_d.err  = 1'b1;   // R3
                        regs_d.done = 1'b1;
                    end else begin
                        regs_d.err       = 1'b0;
                        regs_d.fsm       = ST_DIV;
                        regs_d.cnt       = '0;
                        regs_d.dvs       = dvs_sig;
                        regs_d.ovfl      = (dvd_sig >= dvs_sig);
                        regs_d.rem       = regs_d.ovfl ? (dvd_sig - dvs_sig) : dvd_sig;
                        regs_d.short_dvs = (dvs_sig[LO_W-1:0] == '0);
                    end
                end
            end
            ST_DIV: begin
                regs_d.rem = step_rem;
                regs_d.quo = {regs_q.quo[SIG_W-2:0], step_bit};
                regs_d.cnt = regs_q.cnt + CNT_W'(1);
                if (regs_q.cnt == CNT_W'(SIG_W-1)) begin
                    regs_d.cnt = '0;
                    regs_d.fsm = regs_q.short_dvs ? ST_EXT : ST_CLS;
                end
            end
            ST_EXT: begin
                regs_d.rem = step_rem;
                regs_d.rnd = {regs_q.rnd[RW_W-2:0], step_bit};
                regs_d.cnt = regs_q.cnt + CNT_W'(1);
                if (regs_q.cnt == CNT_W'(RW_W-1)) begin
                    regs_d.cnt = '0;
                    regs_d.fsm = ST_ALN;
                end
            end
            ST_CLS: begin
                regs_d.rnd = cls_code;
                regs_d.fsm = ST_ALN;
            end
            ST_ALN: begin
                if (regs_q.ovfl) begin
                    regs_d.quo = {1'b1, regs_q.quo[SIG_W-1:1]};
                    regs_d.rnd = {regs_q.quo[0], regs_q.rnd[RW_W-1:1]};
                end
                regs_d.res_e = regs_q.res_e + XW'(regs_q.ovfl) - XW'(1);
                regs_d.done  = 1'b1;
                regs_d.fsm   = ST_IDLE;
            end
            default: regs_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign quo     = regs_q.quo;
    assign rnd     = regs_q.rnd;
    assign res_exp = regs_q.res_e;
    assign busy    = (regs_q.fsm != ST_IDLE);
    assign done    = regs_q.done;
    assign err     = regs_q.err;

    assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (regs_q.rem < regs_q.dvs))
        else $error("partial remainder not below divisor");

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |=> !done)
        else $error("done longer than one cycle");

    assert_busy_done_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done)
        else $error("busy and done together");

    assert_ignore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(regs_q.dvs))
        else $error("start while busy changed the operand");

    assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (quo == '0 && rnd == '0))
        else $error("error result not cleared");

    assert_ovfl_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && regs_q.ovfl) |-> quo[SIG_W-1])
        else $error("realigned quotient lacks leading one");

    assert_exp_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (res_exp >= FLOOR_V - XW'(1)))
        else $error("exponent below clamp");
endmodule

// File: tb/test_fdiv_core.sv
module test_fdiv_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] dvd_sig = '0, dvs_sig = '0;
    logic signed [15:0] dvd_exp = '0, dvs_exp = '0;
    logic [63:0] quo;
    logic [31:0] rnd;
    logic signed [17:0] res_exp;
    logic busy, done, err;

    fdiv_core i_fdiv_core (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dvd_sig(dvd_sig), .dvs_sig(dvs_sig), .dvd_exp(dvd_exp), .dvs_exp(dvs_exp),
        .quo(quo), .rnd(rnd), .res_exp(res_exp), .busy(busy), .done(done), .err(err)
    );

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    bit run_chk = 0, ign_phase = 0;

    // behavioural model state
    logic m_busy = 0, m_done = 0;
    int m_left = 0;
    logic [63:0] e_quo;
    logic [31:0] e_rnd;
    int e_exp;
    logic e_err, e_ov, e_short;
    logic [63:0] r0;
    logic [159:0] qw;
    logic [127:0] rm, rm2;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic predict();
        int base;
        base = int'(dvd_exp) - int'(dvs_exp) + 16383;
        if (base <= -24576) base = -24576;
        e_err = !dvs_sig[63];
        e_quo = '0;
        e_rnd = '0;
        e_exp = base;
        e_ov = 0;
        e_short = (dvs_sig[31:0] == 32'h0);
        if (!e_err) begin
            e_ov = (dvd_sig >= dvs_sig);
            r0 = e_ov ? dvd_sig - dvs_sig : dvd_sig;
            qw = {r0, 96'h0} / {96'h0, dvs_sig};
            rm = {r0, 64'h0} % {64'h0, dvs_sig};
            rm2 = rm << 1;
            e_quo = qw[95:32];
            if (e_short) e_rnd = qw[31:0];
            else if (rm == 0) e_rnd = 32'h00000000;
            else if (rm2 < {64'h0, dvs_sig}) e_rnd = 32'h70000000;
            else if (rm2 == {64'h0, dvs_sig}) e_rnd = 32'h80000000;
            else e_rnd = 32'hFF000000;
            if (e_ov) begin
                e_rnd = {e_quo[0], e_rnd[31:1]};
                e_quo = {1'b1, e_quo[63:1]};
            end
            e_exp = base + (e_ov ? 1 : 0) - 1;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (start) begin
                predict();
                if (e_err) m_done = 1;
                else begin m_busy = 1; m_left = e_short ? 97 : 66; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            chk(busy == m_busy, "R8 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R8 done", 64'(done), 64'(m_done));
            if (m_done && done) begin
                if (e_err) begin
                    chk(err == 1'b1, "R3 err", 64'(err), 64'd1);
                    chk(quo == 64'h0 && rnd == 32'h0, "R3 cleared", quo, 64'h0);
                end else begin
                    chk(err == 1'b0, "R3 err clear", 64'(err), 64'd0);
                    chk(quo == e_quo, ign_phase ? "R9 quo" : (e_ov ? "R4 quo" : "R5 quo"), quo, e_quo);
                    chk(rnd == e_rnd, ign_phase ? "R9 rnd" : (e_short ? "R7 rnd" : "R6 rnd"),
                        64'(rnd), 64'(e_rnd));
                    chk(int'(res_exp) == e_exp, "R1 R2 exp", 64'(res_exp), 64'(e_exp));
                    chk(quo[63] == 1'b1, "R10 msb", 64'(quo[63]), 64'd1);
                end
            end
        end
    end

    task automatic op(input logic [63:0] a, input logic [63:0] b,
                      input logic signed [15:0] ea, input logic signed [15:0] eb);
        dvd_sig = a; dvs_sig = b; dvd_exp = ea; dvs_exp = eb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy || m_done) @(negedge clk);
    endtask

    function automatic logic [63:0] rnd_sig();
        return {1'b1, 31'($urandom), $urandom};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && err == 0, "R8 reset", {busy, done, err}, 64'h0);
        run_chk = 1;

        // largest dividend over smallest divisor (short path)
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 16'sd100, 16'sd50);
        // smallest over largest
        op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, -16'sd7, 16'sd9);
        // equal significands, long and short divisor
        op(64'hC000_0000_0000_0001, 64'hC000_0000_0000_0001, 16'sd0, 16'sd0);
        op(64'hA000_0000_0000_0000, 64'hA000_0000_0000_0000, 16'sd3, -16'sd3);
        op(64'hC000_0000_0000_0000, 64'h8000_0000_0000_0000, 16'sd1, 16'sd1);
        // exponent floor R1
        op(rnd_sig(), rnd_sig(), -16'sd32768, 16'sd32767);
        op(rnd_sig(), rnd_sig(), -16'sd8193, 16'sd0);
        op(rnd_sig(), rnd_sig(), 16'sd32767, -16'sd32768);
        // unnormalized divisor R3
        op(rnd_sig(), 64'h7FFF_FFFF_FFFF_FFFF, 16'sd5, 16'sd5);
        op(rnd_sig(), rnd_sig(), 16'sd5, 16'sd5);

        for (int i = 0; i < 60; i++) begin
            logic [63:0] a, b;
            a = rnd_sig();
            b = rnd_sig();
            if (i % 3 == 0) b[31:0] = 32'h0;
            op(a, b, 16'($urandom), 16'($urandom));
        end

        // R9: start while busy is ignored
        ign_phase = 1;
        dvd_sig = rnd_sig(); dvs_sig = rnd_sig(); dvd_exp = 16'sd40; dvs_exp = 16'sd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        dvd_sig = rnd_sig(); dvs_sig = {rnd_sig()} >> 1; dvd_exp = -16'sd40;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy || m_done) @(negedge clk);
        ign_phase = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R8 actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule